// File: doc/BRIEF.md
# Dual-Channel Gated Binary Counter

The block holds two independent 4-bit binary up-counters. Each channel has two count-input pins, and either pin can serve as the count clock while the other acts as a level enable. Counting on the first pin happens on its rising edge while the second pin is high. Counting on the second pin happens on its falling edge while the first pin is low. Each channel also has an active-high clear that forces its count to zero at once.

Both count-input pins are treated as asynchronous signals. A free-running system clock samples them through a two-stage synchronizer, and their transitions are found by comparing successive samples. Every bit of the count register changes on the same system-clock edge. The clear acts asynchronously on the count register but is released in step with the system clock. Bit 3 of each count is the terminal bit, and stages can be chained from it.

Top module: `gated_count_dual`

## Requirements
- R1: After rst_ni is released, every bit of q_o reads 0.
- R2: A 0-to-1 transition on a channel's cp0_i, while that channel's cp1_i was high before the transition, raises that channel's count by one.
- R3: A 1-to-0 transition on a channel's cp1_i, while that channel's cp0_i was low before the transition, raises that channel's count by one.
- R4: No other transition counts. This covers a cp0_i rise while cp1_i was low, a cp1_i fall while cp0_i was high, any cp0_i fall and any cp1_i rise. In each of these cases the count keeps its value.
- R5: The count wraps from 15 to 0 and does not saturate.
- R6: The enable level is the level the other pin had before the change. A cp0_i rise and a cp1_i fall in the same sample, starting from cp0_i=0 and cp1_i=1, therefore raise the count by exactly one.
- R7: A counted transition shows on q_o after the third rising edge of clk_i that follows the pin change, and not after the second.
- R8: While a channel's mr_i is high, that channel's q_o is 0. The clear takes effect without waiting for a clk_i edge.
- R9: After mr_i falls, counting resumes two clk_i rising edges later. Pin transitions made while mr_i was high leave no count behind.
- R10: The channels are independent. A channel's pins and mr_i never change the other channel's count.
- Channel c drives q_o[4c+3:4c], with bit 4c as the least significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock used to sample the pins |
| rst_ni | input | 1 | Active-low asynchronous reset for the whole block |
| cp0_i | input | 2 | Per-channel count pin, counts on its rising edge; bit c belongs to channel c |
| cp1_i | input | 2 | Per-channel count pin, counts on its falling edge; bit c belongs to channel c |
| mr_i | input | 2 | Per-channel active-high clear |
| q_o | output | 8 | Counts, 4 bits per channel; channel c at [4c+3:4c] |

## Verification
A pin change driven on a falling clock edge passes through two synchronizer stages and one count-register update, so it reaches q_o after the third rising edge. The bench checks every pin step twice. The first check comes one falling edge after the second rising edge, where the old value must still hold. The second comes one falling edge after the third, where the new value must hold. A clear is checked one time unit after mr_i rises, with no clock edge in between. After mr_i falls, the bench first confirms that no count was left behind and only then resumes stepping, which gives the two-edge clear release time to finish. The bench walks through all sixteen pairs of old and new pin levels on each channel. For every step it computes the expected count of both channels from the requirements.

// File: rtl/gc_pkg.sv
package gc_pkg;
  typedef struct packed {
    logic lvl0;  // current synced cp0
    logic lvl1;  // current synced cp1
    logic prv0;  // previous synced cp0
    logic prv1;  // previous synced cp1
  } pin_state_t;
endpackage

// File: rtl/gc_pin_sync.sv
module gc_pin_sync
  import gc_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cp0_i,
  input  logic       cp1_i,
  output pin_state_t st_o
);
  logic [STAGES-1:0] sh0_q, sh1_q;
  logic              prv0_q, prv1_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          sh0_q <= '0;
          sh1_q <= '0;
        end else begin
          sh0_q <= cp0_i;
          sh1_q <= cp1_i;
        end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          sh0_q <= '0;
          sh1_q <= '0;
        end else begin
          sh0_q <= {sh0_q[STAGES-2:0], cp0_i};
          sh1_q <= {sh1_q[STAGES-2:0], cp1_i};
        end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      prv0_q <= 1'b0;
      prv1_q <= 1'b0;
    end else begin
      prv0_q <= sh0_q[STAGES-1];
      prv1_q <= sh1_q[STAGES-1];
    end

  assign st_o = '{lvl0: sh0_q[STAGES-1], lvl1: sh1_q[STAGES-1],
                  prv0: prv0_q, prv1: prv1_q};
endmodule

// File: rtl/gc_event.sv
module gc_event
  import gc_pkg::*;
(
  input  pin_state_t st_i,
  output logic       evt_o
);
  logic rise0_ok, fall1_ok;
  // enable level is taken from the sample before the transition
  assign rise0_ok = st_i.lvl0 & ~st_i.prv0 & st_i.prv1;
  assign fall1_ok = ~st_i.lvl1 & st_i.prv1 & ~st_i.prv0;
  assign evt_o    = rise0_ok | fall1_ok;
endmodule

// File: rtl/gc_clear_sync.sv
module gc_clear_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mr_i,
  output logic run_o
);
  logic              arst;
  logic [STAGES-1:0] rel_q;

  assign arst = mr_i | ~rst_ni;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or posedge arst)
        if (arst) rel_q <= '0;
        else      rel_q <= 1'b1;
    end else begin : g_many
      always_ff @(posedge clk_i or posedge arst)
        if (arst) rel_q <= '0;
        else      rel_q <= {rel_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  assign run_o = rel_q[STAGES-1];
endmodule

// File: rtl/gc_channel.sv
module gc_channel
  import gc_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cp0_i,
  input  logic             cp1_i,
  input  logic             mr_i,
  output logic [CNT_W-1:0] q_o
);
  pin_state_t       st;
  logic             evt, run;
  logic [CNT_W-1:0] cnt_q;

  gc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .cp0_i(cp0_i), .cp1_i(cp1_i), .st_o(st)
  );

  gc_event u_evt (.st_i(st), .evt_o(evt));

  gc_clear_sync #(.STAGES(SYNC_STAGES)) u_clr (
    .clk_i(clk_i), .rst_ni(rst_ni), .mr_i(mr_i), .run_o(run)
  );

  always_ff @(posedge clk_i or negedge run)
    if (!run)     cnt_q <= '0;
    else if (evt) cnt_q <= cnt_q + 1'b1;

  assign q_o = cnt_q;

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_i |-> cnt_q == '0);

  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mr_i) |-> !run);

  // single step with wrap, covers R2 R3 R5 R6
  assert_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || mr_i)
    (run && evt) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || mr_i)
    (run && !evt) |=> $stable(cnt_q));
endmodule

// File: rtl/gated_count_dual.sv
module gated_count_dual #(
  parameter int unsigned N_CH        = 2,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH-1:0]       cp0_i,
  input  logic [N_CH-1:0]       cp1_i,
  input  logic [N_CH-1:0]       mr_i,
  output logic [N_CH*CNT_W-1:0] q_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    gc_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cp0_i (cp0_i[c]),
      .cp1_i (cp1_i[c]),
      .mr_i  (mr_i[c]),
      .q_o   (q_o[c*CNT_W +: CNT_W])
    );
  end
endmodule

// File: tb/sim_gated_count_dual.sv
module sim_gated_count_dual;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 2;
  localparam int W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N_CH-1:0] cp0 = '0, cp1 = '0, mr = '0;
  logic [N_CH*W-1:0] q;

  int errors = 0, checks = 0;
  bit done = 0;
  int exp_q[N_CH];
  bit m0[N_CH], m1[N_CH];

  gated_count_dual u0 (.clk_i(clk), .rst_ni(rst_n), .cp0_i(cp0), .cp1_i(cp1),
                       .mr_i(mr), .q_o(q));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < N_CH; c++) check(req, int'(q[c*W +: W]), exp_q[c]);
  endtask

  // drive one channel's pins, check hold after 2 edges and result after 3 (R7)
  task automatic step(input int ch, input bit a0, input bit a1, input string req);
    bit ev;
    @(negedge clk);
    cp0[ch] = a0;
    cp1[ch] = a1;
    ev = (a0 && !m0[ch] && m1[ch]) || (!a1 && m1[ch] && !m0[ch]);
    m0[ch] = a0;
    m1[ch] = a1;
    repeat (2) @(negedge clk);
    check("R7 hold", int'(q[ch*W +: W]), exp_q[ch]);
    if (ev && !mr[ch]) exp_q[ch] = (exp_q[ch] + 1) % 16;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    for (int c = 0; c < N_CH; c++) begin exp_q[c] = 0; m0[c] = 0; m1[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 reset");

    // R2: cp1 high, cp0 pulses on channel 0; R5 wrap after 16; R10 ch1 stays 0
    step(0, 0, 1, "R2 setup");
    for (int i = 0; i < 17; i++) begin
      step(0, 1, 1, "R2/R5/R10 cp0 rise");
      step(0, 0, 1, "R4 cp0 fall");
    end
    check(" R5 wrapped", int'(q[3:0]), 1);

    // R3: cp0 low, cp1 pulses on channel 1
    for (int i = 0; i < 18; i++) begin
      step(1, 0, 1, "R4 cp1 rise");
      step(1, 0, 0, "R3/R5/R10 cp1 fall");
    end

    // R4: wrong enable level blocks counting
    step(0, 0, 0, "R4 setup");
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 0, "R4 cp0 rise cp1 low");
      step(0, 0, 0, "R4 cp0 fall");
    end
    step(1, 1, 0, "R4 setup");
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 1, "R4 cp1 rise");
      step(1, 1, 0, "R4 cp1 fall cp0 high");
    end

    // R6: simultaneous qualifying edges count once
    step(0, 0, 1, "R6 setup");
    step(0, 1, 0, "R6 both edges");
    step(1, 0, 1, "R6 setup");
    step(1, 1, 0, "R6 both edges");

    // exhaustive old->new pin pairs on both channels
    for (int c = 0; c < N_CH; c++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          step(c, a[0], a[1], "R2/R3/R4/R6 sweep from");
          step(c, b[0], b[1], "R2/R3/R4/R6 sweep to");
        end

    // R8/R9: clear during activity
    step(0, 0, 1, "R8 setup");
    step(0, 1, 1, "R8 setup");
    @(negedge clk);
    mr[0] = 1'b1;
    #1;
    exp_q[0] = 0;
    check("R8 immediate", int'(q[3:0]), 0);
    check("R10 clear isolation", int'(q[7:4]), exp_q[1]);
    step(0, 0, 1, "R8 hold");
    step(0, 1, 1, "R8 hold");
    step(0, 0, 1, "R8 hold");
    @(negedge clk);
    mr[0] = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R9 no leftover count");
    step(0, 1, 1, "R9 resume");
    step(0, 0, 1, "R9 resume");
    step(0, 1, 1, "R9 resume");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule